// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory with registered address, control and write data. Reads and writes may follow each other on consecutive clocks in any mix, with no idle cycle between them. Every access is issued on a rising edge. A cycle can start a new access, continue a four-beat burst, deselect the memory, or be skipped entirely by the clock enable. A burst advances its two low address bits in linear or interleaved order, and the order is chosen by a static mode pin.

A write presents its address and lane enables first. Its data arrives two enabled edges later, and the array takes the data on that same edge. A read returns its data two enabled edges after its address. A read that samples the array in the same cycle as a committing write takes the lanes being written straight from the data input, so every read returns the newest value. Outputs are registered. An asynchronous output enable and the access type together decide whether the data bus is driven, and that decision is modelled as a separate drive-enable output.

Top module: `zt_sram`

## Requirements
- R1: A synchronous reset leaves the memory deselected with no access in flight, so `dout_oe` is 0 on the cycle after reset.
- R2: A read started by a selected load cycle (`adv`=0, `wr_n`=1) shows the word on `dout` with `dout_oe`=1 (when `oe_n`=0) after the second enabled clock edge that follows its address edge.
- R3: A write takes its data from `din` on the second enabled edge after its address edge. Only lanes whose `lane_we_n` bit was 0 at the address edge change. Lane i is `din[9*i+8 : 9*i]`.
- R4: A write with every `lane_we_n` bit at 1 leaves the addressed word unchanged.
- R5: Whether an access reads or writes is fixed at the load cycle. On continue cycles (`adv`=1), `wr_n` has no effect.
- R6: Each continue cycle moves to the next beat of a four-word burst. The upper address bits are kept. With `burst_ilv`=0 the low two bits are (start + n) mod 4, and with `burst_ilv`=1 they are start XOR n, for beat n = 1..3.
- R7: Three selects (`sel_n_a` and `sel_n_b` active low, `sel_c` active high) are sampled only on load cycles. If any one of them is inactive, the cycle reads and writes nothing and its output slot is undriven.
- R8: A continue cycle that follows a deselect stays deselected and produces no access.
- R9: With `cken_n`=1 an edge is ignored. No write takes place, pipeline state holds, and `dout` and `dout_oe` keep their values.
- R10: A read whose address follows a write to the same word returns the written lanes even while that write is still on its way to the array. Unwritten lanes keep their old contents.
- R11: Output slots of write cycles are never driven, whatever `oe_n` is. During a read slot `oe_n`=1 turns the drive off (dummy read).
- R12: Reads and writes alternate on consecutive enabled cycles with no idle cycle, and each one still returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cken_n | input | 1 | Clock enable, active low; high ignores the edge |
| adv | input | 1 | 0 loads a new address, 1 continues the burst |
| wr_n | input | 1 | Access type on load: 0 write, 1 read |
| sel_n_a | input | 1 | Select, active low, sampled on load |
| sel_n_b | input | 1 | Select, active low, sampled on load |
| sel_c | input | 1 | Select, active high, sampled on load |
| lane_we_n | input | LANES | Per-lane write enables, active low, taken with the address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, two enabled edges after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | Bus drive enable for `dout` |

## Verification
The latency properties assume that reset is applied with `cken_n` high, so no access edge is lost. They also assume that `burst_ilv` changes only between bursts and that `oe_n` changes only away from the sampling point. The stimulus follows these rules. It drives every input at the falling edge, changes the burst mode only while the memory is idle, and toggles `oe_n` only between accesses. Reads target only words that were written earlier, so each expected value comes from a defined reference model. Writes are placed one and two cycles ahead of reads to the same word, which exercises both the array path and the same-edge bypass.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;

   // Kind of edge seen by the command stage.
   typedef enum logic [1:0] {
      CK_HOLD = 2'd0,   // clock enable inactive
      CK_LOAD = 2'd1,   // new address taken
      CK_NEXT = 2'd2,   // burst beat of a live access
      CK_IDLE = 2'd3    // continue while deselected
   } cyc_e;

   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_e;

endpackage

// File: rtl/zt_cmd_ctrl.sv
`timescale 1ns/1ps
module zt_cmd_ctrl
   import zt_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 2,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              adv,
   input  logic              wr_n,
   input  logic              sel_ok,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              burst_ilv,
   input  logic [ADDR_W-1:0] addr,
   output logic              s1_vld,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_be
);

   localparam logic [BURST_W-1:0] BEAT_ONE = 1;

   logic               act_q;
   acc_e               acc_q;
   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_nx;
   logic [BURST_W-1:0] lo_nx;
   cyc_e               kind;

   always_comb begin
      if (!en)        kind = CK_HOLD;
      else if (!adv)  kind = CK_LOAD;
      else if (act_q) kind = CK_NEXT;
      else            kind = CK_IDLE;
   end

   assign cnt_nx = cnt_q + BEAT_ONE;

   // Burst order variant: xor for interleaved, wrapping add for linear.
   assign lo_nx = burst_ilv ? (base_q[BURST_W-1:0] ^ cnt_nx)
                            : (base_q[BURST_W-1:0] + cnt_nx);

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q  <= 1'b0;
         s1_vld <= 1'b0;
      end else begin
         case (kind)
            CK_LOAD: begin
               act_q  <= sel_ok;
               s1_vld <= sel_ok;
            end
            CK_NEXT: s1_vld <= 1'b1;
            CK_IDLE: s1_vld <= 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      case (kind)
         CK_LOAD: begin
            base_q  <= addr;
            cnt_q   <= '0;
            acc_q   <= wr_n ? ACC_RD : ACC_WR;
            s1_wr   <= ~wr_n;
            s1_addr <= addr;
            s1_be   <= ~lane_we_n;
         end
         CK_NEXT: begin
            cnt_q   <= cnt_nx;
            s1_wr   <= (acc_q == ACC_WR);
            s1_addr <= {base_q[ADDR_W-1:BURST_W], lo_nx};
            s1_be   <= ~lane_we_n;
         end
         CK_IDLE: s1_be <= ~lane_we_n;
         default: ;
      endcase
   end

endmodule

// File: rtl/zt_lane_ram.sv
`timescale 1ns/1ps
module zt_lane_ram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic                     wr_go,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [LANES-1:0]         wr_be,
   input  logic [LANES*LANE_W-1:0]  wr_data,
   input  logic                     rd_go,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [LANES*LANE_W-1:0]  rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic fwd_hit;

   // The write that commits on this edge is the newest copy of its word.
   assign fwd_hit = wr_go && (wr_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (en) begin
            if (wr_go && wr_be[g])
               cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            if (rd_go)
               rd_q <= (fwd_hit && wr_be[g]) ? wr_data[g*LANE_W +: LANE_W]
                                             : cells[rd_addr];
         end
      end

      assign rd_data[g*LANE_W +: LANE_W] = rd_q;
   end

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 2,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cken_n,
   input  logic                     adv,
   input  logic                     wr_n,
   input  logic                     sel_n_a,
   input  logic                     sel_n_b,
   input  logic                     sel_c,
   input  logic [LANES-1:0]         lane_we_n,
   input  logic                     burst_ilv,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES*LANE_W-1:0]  din,
   input  logic                     oe_n,
   output logic [LANES*LANE_W-1:0]  dout,
   output logic                     dout_oe
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr_w
      $error("zt_sram: ADDR_W must be larger than BURST_W");
   end
   if (BURST_W < 1 || BURST_W > 4) begin : g_bad_burst_w
      $error("zt_sram: BURST_W must lie in 1..4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zt_sram: LANES and LANE_W must be positive");
   end

   logic              en;
   logic              sel_ok;
   logic              s1_vld, s1_wr;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_be;
   logic              s2_vld, s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_be;
   logic [DATA_W-1:0] ram_rd;
   logic [DATA_W-1:0] dout_q;
   logic              out_vld;

   assign en     = ~cken_n;
   assign sel_ok = ~sel_n_a & ~sel_n_b & sel_c;

   zt_cmd_ctrl #(
      .ADDR_W  (ADDR_W),
      .LANES   (LANES),
      .BURST_W (BURST_W)
   ) u_cmd (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .adv       (adv),
      .wr_n      (wr_n),
      .sel_ok    (sel_ok),
      .lane_we_n (lane_we_n),
      .burst_ilv (burst_ilv),
      .addr      (addr),
      .s1_vld    (s1_vld),
      .s1_wr     (s1_wr),
      .s1_addr   (s1_addr),
      .s1_be     (s1_be)
   );

   // Second address stage: the write waiting here takes din on the next edge.
   always_ff @(posedge clk) begin
      if (rst) begin
         s2_vld  <= 1'b0;
         out_vld <= 1'b0;
      end else if (en) begin
         s2_vld  <= s1_vld;
         out_vld <= s2_vld & ~s2_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
         dout_q  <= ram_rd;
      end
   end

   zt_lane_ram #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_ram (
      .clk     (clk),
      .en      (en),
      .wr_go   (s2_vld & s2_wr),
      .wr_addr (s2_addr),
      .wr_be   (s2_be),
      .wr_data (din),
      .rd_go   (s1_vld & ~s1_wr),
      .rd_addr (s1_addr),
      .rd_data (ram_rd)
   );

   assign dout    = dout_q;
   assign dout_oe = out_vld & ~oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst,
   input logic              cken_n,
   input logic              adv,
   input logic              wr_n,
   input logic              sel_n_a,
   input logic              sel_n_b,
   input logic              sel_c,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe
);

   logic sel_ok;
   assign sel_ok = ~sel_n_a & ~sel_n_b & sel_c;

   AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> !dout_oe);                                              // R1

   AST_READ_LAT: assert property (@(posedge clk) disable iff (rst)
      (!cken_n && !adv && wr_n && sel_ok) ##1 !cken_n ##1 !cken_n
      |=> (dout_oe || oe_n));                                         // R2

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!cken_n && !adv && !sel_ok) ##1 !cken_n ##1 !cken_n
      |=> !dout_oe);                                                  // R7

   AST_CONT_DESEL: assert property (@(posedge clk) disable iff (rst)
      (!cken_n && !adv && !sel_ok) ##1 (!cken_n && adv) ##1 !cken_n ##1 !cken_n
      |=> !dout_oe);                                                  // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      cken_n |=> $stable(dout));                                      // R9

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!cken_n && !adv && !wr_n && sel_ok) ##1 !cken_n ##1 !cken_n
      |=> !dout_oe);                                                  // R11

   AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
      dout_oe |-> !oe_n);                                             // R11

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cken_n  (cken_n),
   .adv     (adv),
   .wr_n    (wr_n),
   .sel_n_a (sel_n_a),
   .sel_n_b (sel_n_b),
   .sel_c   (sel_c),
   .oe_n    (oe_n),
   .dout    (dout),
   .dout_oe (dout_oe)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

   localparam int AW = 6;
   localparam int LN = 2;
   localparam int LW = 9;
   localparam int DW = LN * LW;
   localparam logic [DW-1:0] JUNK = 18'h2B6D9;

   logic          clk = 1'b0;
   logic          rst, cken_n, adv, wr_n, sel_n_a, sel_n_b, sel_c, burst_ilv, oe_n;
   logic [LN-1:0] lane_we_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic          dout_oe;

   zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2)) u_zt_sram (
      .clk(clk), .rst(rst), .cken_n(cken_n), .adv(adv), .wr_n(wr_n),
      .sel_n_a(sel_n_a), .sel_n_b(sel_n_b), .sel_c(sel_c),
      .lane_we_n(lane_we_n), .burst_ilv(burst_ilv), .addr(addr), .din(din),
      .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe)
   );

   always #2 clk = ~clk;

   typedef struct {
      bit            rd;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   exp_t          sb_q[$];
   logic [DW-1:0] dq[$];
   logic [DW-1:0] mdl [1 << AW];
   int            n_run = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   // reference burst state
   bit            m_act = 1'b0;
   bit            m_wr;
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;

   task automatic op(input bit en, input bit ld, input bit wr,
                     input bit sa, input bit sb, input bit sc,
                     input logic [LN-1:0] ben, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
      logic [AW-1:0] cur;
      exp_t          e;
      @(negedge clk);
      cken_n = !en; adv = !ld; wr_n = !wr;
      sel_n_a = sa; sel_n_b = sb; sel_c = sc;
      lane_we_n = ben; addr = a;
      if (!en) begin
         din = JUNK;
      end else begin
         cur = '0;
         if (ld) begin
            m_act = (!sa && !sb && sc);
            m_base = a; m_cnt = 2'd0; m_wr = wr; cur = a;
         end else if (m_act) begin
            m_cnt = m_cnt + 2'd1;
            cur = {m_base[AW-1:2],
                   burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
         end
         e.tag = tag; e.rd = 1'b0; e.data = '0;
         if (m_act && m_wr) begin
            for (int i = 0; i < LN; i++)
               if (!ben[i]) mdl[cur][i*LW +: LW] = d[i*LW +: LW];
            dq.push_back(d);
         end else begin
            if (m_act) begin
               e.rd = 1'b1; e.data = mdl[cur];
            end
            dq.push_back(JUNK);
         end
         sb_q.push_back(e);
         din = (dq.size() == 3) ? dq[0] : JUNK;
      end
      @(posedge clk);
      if (en && dq.size() == 3) void'(dq.pop_front());
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] ben,
                     input logic [DW-1:0] d, input string tag);
      op(1, 1, 1, 0, 0, 1, ben, a, d, tag);
   endtask
   task automatic rd(input logic [AW-1:0] a, input string tag);
      op(1, 1, 0, 0, 0, 1, '1, a, JUNK, tag);
   endtask
   task automatic cont(input bit wrpin, input logic [LN-1:0] ben,
                       input logic [DW-1:0] d, input string tag);
      op(1, 0, wrpin, 0, 0, 1, ben, '0, d, tag);
   endtask
   task automatic idle();
      op(1, 1, 0, 1, 1, 0, '1, '0, JUNK, "R7");
   endtask
   task automatic stall(input string tag);
      op(0, 0, 1, 0, 0, 1, '0, '0, JUNK, tag);
   endtask

   // monitor: one scoreboard entry emerges per enabled edge, two edges late
   initial begin
      exp_t cur;
      bit   have = 1'b0;
      bit   exp_drv;
      forever begin
         @(posedge clk); #1;
         if (rst) begin
            sb_q.delete(); have = 1'b0;
         end else begin
            if (!cken_n && sb_q.size() == 3) begin
               cur = sb_q.pop_front(); have = 1'b1;
            end
            if (have) begin
               exp_drv = cur.rd && !oe_n;
               n_run++;
               if (dout_oe !== exp_drv) begin
                  n_fail++;
                  $display("FAIL %s drive actual=%0b expected=%0b", cur.tag, dout_oe, exp_drv);
               end
               if (exp_drv) begin
                  n_run++;
                  if (dout !== cur.data) begin
                     n_fail++;
                     $display("FAIL %s data actual=%h expected=%h", cur.tag, dout, cur.data);
                  end
               end
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1; cken_n = 1; adv = 0; wr_n = 1; sel_n_a = 1; sel_n_b = 1; sel_c = 0;
      lane_we_n = '1; burst_ilv = 0; addr = '0; din = '0; oe_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      @(posedge clk); #1;
      n_run++;
      if (dout_oe !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 drive after reset actual=%0b expected=0", dout_oe);
      end

      // R3 fill, R2 read back
      for (int i = 0; i < 13; i++) wr(AW'(i), 2'b00, DW'(i * 18'h0B35 + 18'h0111), "R3");
      for (int i = 0; i < 8; i++) rd(AW'(i), "R2");

      // R12 alternation with R10 forwarding
      wr(10, 2'b00, 18'h2A5A5, "R12");
      rd(10, "R10");
      rd(3, "R12");
      wr(11, 2'b00, 18'h15A5A, "R12");
      rd(11, "R10");
      wr(12, 2'b00, 18'h0F0F0, "R12");
      rd(0, "R12");
      rd(12, "R10");

      // R3 lane writes, R10 partial forwarding
      wr(2, 2'b10, 18'h3FFFF, "R3");
      rd(2, "R10");
      idle(); idle();
      rd(2, "R3");
      wr(2, 2'b01, 18'h00000, "R3");
      idle(); idle(); idle();
      rd(2, "R3");

      // R4 abort
      wr(4, 2'b11, 18'h12345, "R4");
      rd(4, "R4");
      idle(); idle(); idle();
      rd(4, "R4");

      // R6 linear burst write from 33, R5 wr_n ignored on continue
      burst_ilv = 0;
      wr(33, 2'b00, 18'h1C001, "R6");
      cont(0, 2'b00, 18'h1C002, "R5");
      cont(0, 2'b00, 18'h1C003, "R5");
      cont(0, 2'b00, 18'h1C004, "R6");
      rd(34, "R6");
      cont(1, 2'b00, JUNK, "R5");
      cont(1, 2'b00, JUNK, "R5");
      cont(1, 2'b00, JUNK, "R6");
      idle(); idle();
      for (int i = 32; i < 36; i++) rd(AW'(i), "R6");

      // R6 interleaved
      idle(); idle();
      burst_ilv = 1;
      rd(35, "R6");
      cont(0, 2'b11, JUNK, "R6");
      cont(0, 2'b11, JUNK, "R6");
      cont(0, 2'b11, JUNK, "R6");
      wr(50, 2'b00, 18'h0AA01, "R6");
      cont(1, 2'b00, 18'h0AA02, "R6");
      cont(1, 2'b00, 18'h0AA03, "R6");
      cont(1, 2'b00, 18'h0AA04, "R6");
      idle(); idle();
      for (int i = 48; i < 52; i++) rd(AW'(i), "R6");
      idle(); idle();
      burst_ilv = 0;

      // R7 each select inactive, deselected write has no effect
      op(1, 1, 0, 1, 0, 1, '1, 1, JUNK, "R7");
      op(1, 1, 0, 0, 1, 1, '1, 1, JUNK, "R7");
      op(1, 1, 0, 0, 0, 0, '1, 1, JUNK, "R7");
      op(1, 1, 1, 0, 0, 0, 2'b00, 5, 18'h3C3C3, "R7");
      idle(); idle();
      rd(5, "R7");

      // R8 continue while deselected
      op(1, 1, 0, 1, 1, 0, '1, 0, JUNK, "R8");
      cont(0, 2'b11, JUNK, "R8");
      cont(1, 2'b00, 18'h11111, "R8");
      cont(0, 2'b11, JUNK, "R8");
      rd(5, "R8");

      // R9 stalls: output holds, stalled edge writes nothing
      rd(1, "R9");
      stall("R9"); stall("R9"); stall("R9");
      rd(7, "R9");
      wr(6, 2'b00, 18'h0ACE1, "R9");
      stall("R9");
      idle();
      stall("R9");
      idle();
      rd(6, "R9");
      rd(0, "R9");
      cont(0, 2'b11, JUNK, "R9");
      stall("R9");
      cont(0, 2'b11, JUNK, "R9");
      stall("R9"); stall("R9");
      cont(0, 2'b11, JUNK, "R9");
      idle(); idle();

      // R11 dummy read with oe_n high; write slots undriven
      @(negedge clk); oe_n = 1;
      rd(0, "R11");
      rd(1, "R11");
      idle(); idle(); idle();
      @(negedge clk); oe_n = 0;
      wr(9, 2'b00, 18'h01234, "R11");
      wr(8, 2'b00, 18'h04321, "R11");
      rd(9, "R11");
      rd(8, "R11");
      idle(); idle(); idle(); idle();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule